// File: doc/BRIEF.md
# Four-Beat Burst Double-Data-Rate SRAM

This block is a synchronous static memory with a double-data-rate port and a fixed burst of four words. A command (load strobe, read/write select, word address) is taken on a rising clock edge. Each accepted command uses the data bus for two full clock cycles and moves four words, one on every clock edge.

Write words are captured on both the rising and falling edges of the clock, each one together with its own per-lane write enables. Read words are launched on both edges and appear one and a half cycles after the command. Outside a read burst the read bus is held at zero with its valid flag low. A pair of echo clocks runs in phase with the read data so that a receiver can capture with them.

A generate-time parameter picks the burst start. In the wide variants the burst begins at the two low address bits and wraps within its group of four. In the narrow variant it always begins at slot zero. Commands can follow each other every two cycles, and the data bus then carries no gap between bursts.

Top module: `qburst_ddr_sram`

## Requirements
- R1: While reset is asserted, and until the first read burst, `rvalid` is 0 and `rdata` is 0.
- R2: A command is accepted on a rising edge only if no command was accepted on the previous rising edge. A load on the edge right after an acceptance is ignored: that write changes no word, that read produces no beats, and the burst in progress completes unchanged.
- R3: For a write accepted on rising edge n, the four write words are sampled on rising edge n+1, the following falling edge, rising edge n+2 and the falling edge after it, in burst order.
- R4: `lane_en` is sampled with every write word. Bit l set (active high) stores bits [l*W+W-1 : l*W] of that word, where W = DATA_W/LANES. With the bit clear, those bits of the stored word keep their old value.
- R5: With ZERO_START=0, beat k of a burst at address A addresses word {A[ADDR_W-1:2], (A[1:0]+k) mod 4}, for k = 0..3.
- R6: With ZERO_START=1, beat k addresses word {A[ADDR_W-1:2], k}. The low two address bits have no effect.
- R7: For a read accepted on rising edge n, beat 0 is on `rdata` during the low half-cycle after rising edge n+1. Beats 1, 2 and 3 follow in the next three half-cycles, and `rvalid` is 1 in exactly those four half-cycles.
- R8: In every half-cycle that carries no read beat, `rvalid` is 0 and `rdata` is 0.
- R9: Commands accepted every second rising edge run back to back. The read beats of consecutive bursts follow each other with no idle half-cycle.
- R10: A read accepted two cycles after a write to the same address returns the newly written words.
- R11: `echo_p` is 1 in the high half of each clock cycle and 0 in the low half. `echo_n` is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; its falling edge is the complementary edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Command strobe, active high |
| rd_nwr | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W | Word address; the low two bits give the burst start |
| lane_en | input | LANES | Per-lane write enables, sampled with each write word |
| wdata | input | DATA_W | Write word, sampled on both clock edges |
| rdata | output | DATA_W | Read word, changes on both clock edges |
| rvalid | output | 1 | High while `rdata` carries a read beat |
| echo_p | output | 1 | Echo clock in phase with the read data |
| echo_n | output | 1 | Complement of `echo_p` |

## Verification
Two instances share one stimulus: a wide one with a wrapping start, and a narrow one that always starts at zero. A model computes the expected bus for every half-cycle from the accepted commands alone. Loads on every rising edge check that the ignored commands leave no trace; a design that accepted them would overwrite memory or push extra beats, and both show up in later reads. A full sweep of start offsets catches a counter that fails to wrap or that starts at the wrong slot, because words would then come back in the wrong order. Random lane enables catch mask bits taken from the wrong edge, and reads issued two cycles after a write catch stale data. The check runs every half-cycle, so a latency that is half a cycle off, or a gap between back-to-back bursts, shows up as a `rvalid` mismatch.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int BEATS = 4;
  localparam int OFF_W = 2;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;

  // slot of beat k inside the group of four, wrapping modulo 4
  function automatic logic [OFF_W-1:0] beat_slot(input logic [OFF_W-1:0] start,
                                                 input logic [OFF_W-1:0] k);
    return start + k;
  endfunction
endpackage

// File: rtl/qb_ctrl.sv
module qb_ctrl
  import qb_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter bit ZERO_START = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_v,
  output logic              acc_rd,
  output logic [ADDR_W-1:0] acc_base,
  output logic              ph1_v,
  output logic              ph1_rd,
  output logic [ADDR_W-1:0] ph1_base,
  output logic              ph2_v,
  output logic              ph2_rd,
  output logic [ADDR_W-1:0] ph2_base
);
  localparam int GRP_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] start_sel;
  logic             take;
  op_e              acc_op_q, acc_op_d;
  op_e              ph1_op_q, ph2_op_q;
  logic             acc_v_q, acc_v_d, ph1_v_q, ph2_v_q;
  logic [ADDR_W-1:0] acc_base_q, acc_base_d, ph1_base_q, ph2_base_q;

  generate
    if (ZERO_START) begin : g_zero_start
      assign start_sel = '0;
    end else begin : g_addr_start
      assign start_sel = addr[OFF_W-1:0];
    end
  endgenerate

  // an edge right after an acceptance is the second cycle of that burst
  always_comb begin
    take       = load_en & ~acc_v_q;
    acc_v_d    = take;
    acc_op_d   = take ? op_e'(rd_nwr) : acc_op_q;
    acc_base_d = take ? {addr[ADDR_W-1:OFF_W], start_sel} : acc_base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_v_q    <= 1'b0;
      acc_op_q   <= OP_WRITE;
      acc_base_q <= '0;
      ph1_v_q    <= 1'b0;
      ph1_op_q   <= OP_WRITE;
      ph1_base_q <= '0;
      ph2_v_q    <= 1'b0;
      ph2_op_q   <= OP_WRITE;
      ph2_base_q <= '0;
    end else begin
      acc_v_q <= acc_v_d;
      ph1_v_q <= acc_v_q;
      ph2_v_q <= ph1_v_q;
      if (take) begin
        acc_op_q   <= acc_op_d;
        acc_base_q <= acc_base_d;
      end
      if (acc_v_q) begin
        ph1_op_q   <= acc_op_q;
        ph1_base_q <= acc_base_q;
      end
      if (ph1_v_q) begin
        ph2_op_q   <= ph1_op_q;
        ph2_base_q <= ph1_base_q;
      end
    end
  end

  assign acc_v    = acc_v_q;
  assign acc_rd   = (acc_op_q == OP_READ);
  assign acc_base = acc_base_q;
  assign ph1_v    = ph1_v_q;
  assign ph1_rd   = (ph1_op_q == OP_READ);
  assign ph1_base = ph1_base_q;
  assign ph2_v    = ph2_v_q;
  assign ph2_rd   = (ph2_op_q == OP_READ);
  assign ph2_base = ph2_base_q;

  logic [GRP_W-1:0] unused_grp;
  assign unused_grp = '0;
endmodule

// File: rtl/qb_wr_path.sv
module qb_wr_path
  import qb_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int LANES  = 2,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_en,
  input  logic              acc_wr,
  input  logic              ph1_wr,
  input  logic              ph2_wr,
  input  logic [ADDR_W-1:0] ph1_base,
  input  logic [ADDR_W-1:0] ph2_base,
  output logic              cm_en,
  output logic [ADDR_W-1:0] cm_addr0,
  output logic [ADDR_W-1:0] cm_addr1,
  output logic [DATA_W-1:0] cm_data0,
  output logic [DATA_W-1:0] cm_data1,
  output logic [LANES-1:0]  cm_mask0,
  output logic [LANES-1:0]  cm_mask1
);
  logic [DATA_W-1:0] rise_d_q, fall_d_q;
  logic [LANES-1:0]  rise_m_q, fall_m_q;
  logic              rise_ld, fall_ld;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  k0, k1;

  // rising edges hold beats 0 and 2, falling edges beats 1 and 3
  always_comb begin
    rise_ld = acc_wr | ph1_wr;
    fall_ld = ph1_wr | ph2_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d_q <= '0;
      rise_m_q <= '0;
    end else if (rise_ld) begin
      rise_d_q <= wdata;
      rise_m_q <= lane_en;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_d_q <= '0;
      fall_m_q <= '0;
    end else if (fall_ld) begin
      fall_d_q <= wdata;
      fall_m_q <= lane_en;
    end
  end

  // a pair of words is committed on each of the two edges after capture
  always_comb begin
    cm_en    = ph1_wr | ph2_wr;
    base     = ph1_wr ? ph1_base : ph2_base;
    k0       = ph1_wr ? OFF_W'(0) : OFF_W'(2);
    k1       = k0 + OFF_W'(1);
    cm_addr0 = {base[ADDR_W-1:OFF_W], beat_slot(base[OFF_W-1:0], k0)};
    cm_addr1 = {base[ADDR_W-1:OFF_W], beat_slot(base[OFF_W-1:0], k1)};
    cm_data0 = rise_d_q;
    cm_data1 = fall_d_q;
    cm_mask0 = rise_m_q;
    cm_mask1 = fall_m_q;
  end
endmodule

// File: rtl/qb_array.sv
module qb_array #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa0,
  input  logic [ADDR_W-1:0] wa1,
  input  logic [DATA_W-1:0] wd0,
  input  logic [DATA_W-1:0] wd1,
  input  logic [LANES-1:0]  wm0,
  input  logic [LANES-1:0]  wm1,
  input  logic [ADDR_W-1:0] ra0,
  input  logic [ADDR_W-1:0] ra1,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bm0, bm1;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane_mask
      assign bm0[l*LANE_W +: LANE_W] = {LANE_W{wm0[l]}};
      assign bm1[l*LANE_W +: LANE_W] = {LANE_W{wm1[l]}};
    end
  endgenerate

  // the two write addresses differ in their low bits, so never collide
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa0] <= (mem[wa0] & ~bm0) | (wd0 & bm0);
      mem[wa1] <= (mem[wa1] & ~bm1) | (wd1 & bm1);
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/qb_rd_path.sv
module qb_rd_path
  import qb_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph1_rdv,
  input  logic              ph2_rdv,
  input  logic [ADDR_W-1:0] ph1_base,
  input  logic [ADDR_W-1:0] ph2_base,
  input  logic [DATA_W-1:0] arr_rise_q,
  input  logic [DATA_W-1:0] arr_fall_q,
  output logic [ADDR_W-1:0] ra_rise,
  output logic [ADDR_W-1:0] ra_fall,
  output logic [DATA_W-1:0] q_rise,
  output logic [DATA_W-1:0] q_fall,
  output logic              v_rise,
  output logic              v_fall
);
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  k_fall, k_rise;
  logic              any_rd;
  logic [DATA_W-1:0] nxt_rise, nxt_fall;

  // falling edges launch beats 0 and 2, rising edges beats 1 and 3
  always_comb begin
    any_rd   = ph1_rdv | ph2_rdv;
    base     = ph1_rdv ? ph1_base : ph2_base;
    k_fall   = ph1_rdv ? OFF_W'(0) : OFF_W'(2);
    k_rise   = k_fall + OFF_W'(1);
    ra_fall  = {base[ADDR_W-1:OFF_W], beat_slot(base[OFF_W-1:0], k_fall)};
    ra_rise  = {base[ADDR_W-1:OFF_W], beat_slot(base[OFF_W-1:0], k_rise)};
    nxt_fall = any_rd ? arr_fall_q : '0;
    nxt_rise = any_rd ? arr_rise_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rise <= '0;
      v_rise <= 1'b0;
    end else begin
      q_rise <= nxt_rise;
      v_rise <= any_rd;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_fall <= '0;
      v_fall <= 1'b0;
    end else begin
      q_fall <= nxt_fall;
      v_fall <= any_rd;
    end
  end
endmodule

// File: rtl/qburst_ddr_sram.sv
module qburst_ddr_sram
  import qb_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int LANES      = 2,
  parameter int ADDR_W     = 6,
  parameter bit ZERO_START = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              echo_p,
  output logic              echo_n
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  // assert at once, release after two rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic              acc_v, acc_rd, ph1_v, ph1_rd, ph2_v, ph2_rd;
  logic [ADDR_W-1:0] acc_base, ph1_base, ph2_base;
  logic              acc_wr, ph1_wr, ph2_wr, ph1_rdv, ph2_rdv;

  qb_ctrl #(.ADDR_W(ADDR_W), .ZERO_START(ZERO_START)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n), .load_en(load_en), .rd_nwr(rd_nwr), .addr(addr),
    .acc_v(acc_v), .acc_rd(acc_rd), .acc_base(acc_base),
    .ph1_v(ph1_v), .ph1_rd(ph1_rd), .ph1_base(ph1_base),
    .ph2_v(ph2_v), .ph2_rd(ph2_rd), .ph2_base(ph2_base)
  );

  assign acc_wr  = acc_v & ~acc_rd;
  assign ph1_wr  = ph1_v & ~ph1_rd;
  assign ph2_wr  = ph2_v & ~ph2_rd;
  assign ph1_rdv = ph1_v & ph1_rd;
  assign ph2_rdv = ph2_v & ph2_rd;

  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr0, cm_addr1, ra_rise, ra_fall;
  logic [DATA_W-1:0] cm_data0, cm_data1, arr_rise_q, arr_fall_q;
  logic [LANES-1:0]  cm_mask0, cm_mask1;

  qb_wr_path #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) wr_i (
    .clk(clk), .rst_n(rst_sync_n), .wdata(wdata), .lane_en(lane_en),
    .acc_wr(acc_wr), .ph1_wr(ph1_wr), .ph2_wr(ph2_wr),
    .ph1_base(ph1_base), .ph2_base(ph2_base),
    .cm_en(cm_en), .cm_addr0(cm_addr0), .cm_addr1(cm_addr1),
    .cm_data0(cm_data0), .cm_data1(cm_data1),
    .cm_mask0(cm_mask0), .cm_mask1(cm_mask1)
  );

  qb_array #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) arr_i (
    .clk(clk), .we(cm_en), .wa0(cm_addr0), .wa1(cm_addr1),
    .wd0(cm_data0), .wd1(cm_data1), .wm0(cm_mask0), .wm1(cm_mask1),
    .ra0(ra_rise), .ra1(ra_fall), .rd0(arr_rise_q), .rd1(arr_fall_q)
  );

  logic [DATA_W-1:0] q_rise, q_fall;
  logic              v_rise, v_fall;

  qb_rd_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst_n(rst_sync_n), .ph1_rdv(ph1_rdv), .ph2_rdv(ph2_rdv),
    .ph1_base(ph1_base), .ph2_base(ph2_base),
    .arr_rise_q(arr_rise_q), .arr_fall_q(arr_fall_q),
    .ra_rise(ra_rise), .ra_fall(ra_fall),
    .q_rise(q_rise), .q_fall(q_fall), .v_rise(v_rise), .v_fall(v_fall)
  );

  // the clock level picks the register of the edge that last launched
  assign rdata  = clk ? q_rise : q_fall;
  assign rvalid = clk ? v_rise : v_fall;
  assign echo_p = clk;
  assign echo_n = ~clk;
endmodule

// File: rtl/qburst_ddr_sram_chk.sv
module qburst_ddr_sram_chk #(
  parameter int ADDR_W     = 6,
  parameter bit ZERO_START = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_v,
  input logic              acc_rd,
  input logic [ADDR_W-1:0] acc_base,
  input logic              ph1_v,
  input logic              ph1_rd,
  input logic              ph2_v,
  input logic              ph2_rd,
  input logic              cm_en,
  input logic              v_rise
);
  // R2
  no_double_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_v |=> !acc_v);

  // R3
  write_commit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_v && !acc_rd) |=> (cm_en ##1 cm_en));

  // R6
  zero_start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_v |-> (ZERO_START == 1'b0 || acc_base[1:0] == 2'b00));

  // R7
  read_beat_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph1_v && ph1_rd) |=> v_rise);

  // R8
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ph1_v && ph1_rd) && !(ph2_v && ph2_rd)) |=> !v_rise);

  // R9
  burst_second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_v |=> (ph2_v && ph2_rd == $past(ph1_rd)));
endmodule

bind qburst_ddr_sram qburst_ddr_sram_chk #(.ADDR_W(ADDR_W), .ZERO_START(ZERO_START)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .acc_v(acc_v), .acc_rd(acc_rd), .acc_base(acc_base),
  .ph1_v(ph1_v), .ph1_rd(ph1_rd), .ph2_v(ph2_v), .ph2_rd(ph2_rd),
  .cm_en(cm_en), .v_rise(v_rise)
);

// File: tb/qburst_ddr_sram_tb_top.sv
module qburst_ddr_sram_tb_top;
  localparam int NC = 1640;
  localparam int NH = 2 * NC + 8;

  logic        clk, rst_n, load_en, rd_nwr;
  logic [5:0]  addr;
  logic [1:0]  lane_en;
  logic [17:0] wdata;
  logic [17:0] rdata_w;
  logic        rvalid_w, echo_p_w, echo_n_w;
  logic [7:0]  rdata_n;
  logic        rvalid_n, echo_p_n, echo_n_n;

  qburst_ddr_sram #(.DATA_W(18), .LANES(2), .ADDR_W(6), .ZERO_START(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .rd_nwr(rd_nwr), .addr(addr),
    .lane_en(lane_en), .wdata(wdata), .rdata(rdata_w), .rvalid(rvalid_w),
    .echo_p(echo_p_w), .echo_n(echo_n_w)
  );

  qburst_ddr_sram #(.DATA_W(8), .LANES(2), .ADDR_W(6), .ZERO_START(1'b1)) dut_nar_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .rd_nwr(rd_nwr), .addr(addr),
    .lane_en(lane_en), .wdata(wdata[7:0]), .rdata(rdata_n), .rvalid(rvalid_n),
    .echo_p(echo_p_n), .echo_n(echo_n_n)
  );

  logic        c_ld [NC];
  logic        c_rd [NC];
  logic [5:0]  c_ad [NC];
  int          c_ph [NC];
  logic [17:0] h_wd [NH];
  logic [1:0]  h_be [NH];
  logic        e_v  [NH];
  logic [17:0] e_w  [NH];
  logic [7:0]  e_n  [NH];
  int          e_ph [NH];
  logic [17:0] mw [64];
  logic [7:0]  mn [64];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    rst_n = 1'b0;
    #26 rst_n = 1'b1;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rtag(input int ph, input bit nar);
    case (ph)
      1:       return nar ? "R2 R3 R6 R9" : "R2 R3 R5 R9";
      2:       return nar ? "R4 R6 R7" : "R4 R5 R7";
      3:       return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic check_half(input int h);
    string tw, tn;
    if (e_v[h]) begin
      tw = rtag(e_ph[h], 1'b0);
      tn = rtag(e_ph[h], 1'b1);
    end else begin
      tw = (h < 16) ? "R1" : "R8";
      tn = tw;
    end
    chk(tw, 32'(rvalid_w), 32'(e_v[h]));
    chk(tw, 32'(rdata_w), e_v[h] ? 32'(e_w[h]) : 32'd0);
    chk(tn, 32'(rvalid_n), 32'(e_v[h]));
    chk(tn, 32'(rdata_n), e_v[h] ? 32'(e_n[h]) : 32'd0);
    chk("R11", 32'(echo_p_w), 32'(h % 2 == 0));
    chk("R11", 32'(echo_n_w), 32'(h % 2 != 0));
    chk("R11", 32'(echo_p_n), 32'(h % 2 == 0));
  endtask

  initial begin
    bit busy;
    // ---- stimulus schedule ----
    for (int c = 0; c < NC; c++) begin
      c_ld[c] = 1'b0; c_rd[c] = 1'b0; c_ad[c] = '0; c_ph[c] = 0;
    end
    for (int h = 0; h < NH; h++) begin
      h_wd[h] = 18'($urandom); h_be[h] = 2'b11;
      e_v[h] = 1'b0; e_w[h] = '0; e_n[h] = '0; e_ph[h] = 0;
    end
    // fill all groups; a load on every edge, every second one must be ignored
    for (int g = 0; g < 16; g++) begin
      c_ld[8+2*g] = 1'b1; c_rd[8+2*g] = 1'b0; c_ad[8+2*g] = 6'(g*4 + g%4); c_ph[8+2*g] = 1;
      c_ld[9+2*g] = 1'b1; c_rd[9+2*g] = 1'b1; c_ad[9+2*g] = 6'($urandom); c_ph[9+2*g] = 1;
    end
    // read every address (every start offset), with ignored writes between
    for (int a = 0; a < 64; a++) begin
      c_ld[42+2*a] = 1'b1; c_rd[42+2*a] = 1'b1; c_ad[42+2*a] = 6'(a); c_ph[42+2*a] = 1;
      c_ld[43+2*a] = 1'b1; c_rd[43+2*a] = 1'b0; c_ad[43+2*a] = 6'($urandom); c_ph[43+2*a] = 1;
    end
    // random mix with random lane enables
    for (int c = 172; c < 1400; c++) begin
      c_ld[c] = ($urandom % 4) != 0; c_rd[c] = 1'($urandom);
      c_ad[c] = 6'($urandom); c_ph[c] = 2;
    end
    for (int h = 2*172; h < 2*1400 + 8; h++) h_be[h] = 2'($urandom);
    // write then read of the same address two cycles later
    for (int k = 0; k < 50; k++) begin
      c_ld[1404+4*k] = 1'b1; c_rd[1404+4*k] = 1'b0; c_ad[1404+4*k] = 6'($urandom); c_ph[1404+4*k] = 3;
      c_ld[1406+4*k] = 1'b1; c_rd[1406+4*k] = 1'b1; c_ad[1406+4*k] = c_ad[1404+4*k]; c_ph[1406+4*k] = 3;
    end
    // ---- reference model from the requirements ----
    busy = 1'b0;
    for (int c = 0; c < NC; c++) begin
      bit acc;
      acc  = c_ld[c] && !busy;
      busy = acc;
      if (acc) begin
        for (int k = 0; k < 4; k++) begin
          logic [5:0] wi, ni;
          wi = {c_ad[c][5:2], 2'(c_ad[c][1:0] + 2'(k))};
          ni = {c_ad[c][5:2], 2'(k)};
          if (!c_rd[c]) begin
            int h;
            h = 2*c + 2 + k;
            for (int l = 0; l < 2; l++) begin
              if (h_be[h][l]) begin
                mw[wi][l*9 +: 9] = h_wd[h][l*9 +: 9];
                mn[ni][l*4 +: 4] = h_wd[h][l*4 +: 4];
              end
            end
          end else begin
            int h;
            h = 2*c + 3 + k;
            e_v[h] = 1'b1; e_w[h] = mw[wi]; e_n[h] = mn[ni]; e_ph[h] = c_ph[c];
          end
        end
      end
    end
    // ---- drive and compare, half-cycle by half-cycle ----
    load_en = 1'b0; rd_nwr = 1'b0; addr = '0; lane_en = '0; wdata = '0;
    for (int c = 0; c < NC; c++) begin
      #2;
      load_en = c_ld[c]; rd_nwr = c_rd[c]; addr = c_ad[c];
      wdata = h_wd[2*c]; lane_en = h_be[2*c];
      #1;
      if (2*c - 1 >= 4) check_half(2*c - 1);
      #3;
      wdata = h_wd[2*c+1]; lane_en = h_be[2*c+1];
      #1;
      if (c == 2) begin
        // R1: reset still asserted here
        chk("R1", 32'(rvalid_w), 32'd0);
        chk("R1", 32'(rdata_w), 32'd0);
      end
      if (2*c >= 4) check_half(2*c);
      #1;
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule